// File: doc/BRIEF.md
# Hall-Commutated Bridge Gate Sequencer

This block produces the six gate commands of a three-phase MOSFET bridge (one high-side and one low-side command per phase) from three Hall-sensor levels and a set of control inputs. The Hall code and a direction bit select which phase is sourced, which is sunk and which floats. A PWM input chops the drive. During the PWM-off interval, two inputs choose the path of the decaying current: fast or slow decay, through body diodes or through synchronous rectification. A brake input shorts the windings through the low sides. A disable input and a protection force-coast input turn every gate off. A protection inhibit input removes only the high sides.

Every phase owns a small state machine with four states. `PH_IDLE` means off with the dead time served. `PH_GAP` means off with the dead-time counter running. `PH_HIGH` means the high side is on, and `PH_LOW` means the low side is on. The transitions are:
- turn-on: `PH_IDLE` to `PH_LOW` or `PH_HIGH`.
- turn-off: `PH_HIGH` or `PH_LOW` to `PH_GAP`.
- expiry-with-request: `PH_GAP` to `PH_LOW` or `PH_HIGH`.
- expiry-idle: `PH_GAP` to `PH_IDLE`.

A high side leaves `PH_IDLE` or `PH_GAP` only while that phase's bootstrap-settled flag is set. Waiting on this flag is not a fault. The dead time is a cycle count supplied on an input bus.

Top module: `bridge_gate_seq`

## Requirements
- R1: Hall bus `hall` = {H1,H2,H3}, with phase A on bit 0, B on bit 1 and C on bit 2 of the gate buses. With `dir`=1 the code selects the (high phase, low phase) pair as follows: 101 gives (A,B), 100 gives (A,C), 110 gives (B,C), 010 gives (B,A), 011 gives (C,A), 001 gives (C,B).
- R2: With `dir`=0 every legal code selects the same two phases as in R1 with their high and low roles swapped.
- R3: With `pwm`=1 the selected high gate and the selected low gate are on. The third phase has both gates off.
- R4: Hall codes 000 and 111 turn all six gates off.
- R5: With `pwm`=0 the gates follow {`decay_slow`,`sync_rect`}. 00 turns all gates off. 10 keeps only the selected low gate on. 01 turns on the low gate of the high phase and the high gate of the low phase. 11 turns on the low gates of both selected phases.
- R6: `brake_n`=0 turns all three low gates on and all three high gates off, whatever the Hall code.
- R7: `drv_disable`=1 turns all gates off and overrides the brake.
- R8: After any gate of a phase falls, neither gate of that phase rises within the next max(`dead_cyc`,1) cycles. A waiting request rises exactly at that point.
- R9: A high gate rises only in a cycle after its `boot_ok` bit was sampled 1. When the bit is set later, the gate rises on the next clock.
- R10: `prot_hs_inhibit`=1 forces all high gates off one cycle later and leaves the low gates as selected.
- R11: `prot_coast`=1 turns all six gates off, the brake included.
- R12: While `rst_n` is low and after its release, all gates are off until a request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall | input | 3 | Hall levels {H1,H2,H3} |
| dir | input | 1 | Rotation direction |
| decay_slow | input | 1 | 1 = slow decay in PWM-off |
| sync_rect | input | 1 | 1 = synchronous rectification in PWM-off |
| pwm | input | 1 | Chop input, 1 = on-time |
| brake_n | input | 1 | Brake, active low |
| drv_disable | input | 1 | Coast all gates, overrides brake |
| prot_coast | input | 1 | Protection force-coast |
| prot_hs_inhibit | input | 1 | Protection high-side inhibit |
| boot_ok | input | 3 | Per-phase bootstrap charge settled |
| dead_cyc | input | DT_W | Dead time in clock cycles |
| gate_hi | output | 3 | High-side gate commands, A at bit 0 |
| gate_lo | output | 3 | Low-side gate commands, A at bit 0 |

## Verification
A PWM falling edge under fast synchronous decay makes two things happen in the same cycle: one phase turns its high side off and requests its low side, and the other phase does the opposite. Both phases must serve the dead time independently. The bench provokes this by dropping `pwm` with {`decay_slow`,`sync_rect`}=01 and counting, cycle by cycle, how long each phase has both gates off before its new gate rises. The count must equal `dead_cyc` (or 1 when it is 0). A second coincidence is the dead-time expiry falling in the same cycle that the bootstrap flag is still clear. The high gate must then stay off and rise on the clock after the flag arrives.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    localparam int NPH = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_GAP  = 2'b01,
        PH_HIGH = 2'b10,
        PH_LOW  = 2'b11
    } ph_state_t;

    typedef enum logic [1:0] {
        DK_FAST_DIODE = 2'b00,
        DK_FAST_SYNC  = 2'b01,
        DK_SLOW_DIODE = 2'b10,
        DK_SLOW_SYNC  = 2'b11
    } decay_t;

endpackage

// File: rtl/bgs_commutator.sv
module bgs_commutator
    import bgs_pkg::*;
(
    input  logic [2:0]     hall,
    input  logic           dir,
    output logic [NPH-1:0] hi_sel,
    output logic [NPH-1:0] lo_sel,
    output logic           code_ok
);
    logic [NPH-1:0] fwd_hi;
    logic [NPH-1:0] fwd_lo;

    always_comb begin
        fwd_hi  = '0;
        fwd_lo  = '0;
        code_ok = 1'b1;
        unique case (hall)
            3'b101: begin fwd_hi = 3'b001; fwd_lo = 3'b010; end
            3'b100: begin fwd_hi = 3'b001; fwd_lo = 3'b100; end
            3'b110: begin fwd_hi = 3'b010; fwd_lo = 3'b100; end
            3'b010: begin fwd_hi = 3'b010; fwd_lo = 3'b001; end
            3'b011: begin fwd_hi = 3'b100; fwd_lo = 3'b001; end
            3'b001: begin fwd_hi = 3'b100; fwd_lo = 3'b010; end
            default: code_ok = 1'b0;
        endcase
    end

    // reverse rotation swaps the roles of the two driven phases
    assign hi_sel = dir ? fwd_hi : fwd_lo;
    assign lo_sel = dir ? fwd_lo : fwd_hi;

endmodule

// File: rtl/bgs_drive_select.sv
module bgs_drive_select
    import bgs_pkg::*;
(
    input  logic [NPH-1:0] hi_sel,
    input  logic [NPH-1:0] lo_sel,
    input  logic           code_ok,
    input  logic           pwm,
    input  logic           decay_slow,
    input  logic           sync_rect,
    input  logic           brake_n,
    input  logic           drv_disable,
    input  logic           prot_coast,
    input  logic           prot_hs_inhibit,
    output logic [NPH-1:0] req_hi,
    output logic [NPH-1:0] req_lo
);
    decay_t decay;
    assign decay = decay_t'({decay_slow, sync_rect});

    always_comb begin
        req_hi = '0;
        req_lo = '0;
        if (drv_disable || prot_coast) begin
            req_hi = '0;
            req_lo = '0;
        end else if (!brake_n) begin
            req_lo = '1;
        end else if (code_ok) begin
            if (pwm) begin
                req_hi = hi_sel;
                req_lo = lo_sel;
            end else begin
                unique case (decay)
                    DK_FAST_DIODE: ;
                    DK_SLOW_DIODE: req_lo = lo_sel;
                    DK_FAST_SYNC: begin
                        req_hi = lo_sel;
                        req_lo = hi_sel;
                    end
                    DK_SLOW_SYNC:  req_lo = hi_sel | lo_sel;
                    default: ;
                endcase
            end
        end
        if (prot_hs_inhibit) req_hi = '0;
    end

endmodule

// File: rtl/bgs_phase_timer.sv
module bgs_phase_timer
    import bgs_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_hi,
    input  logic            req_lo,
    input  logic            boot_ok,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            gate_hi,
    output logic            gate_lo
);
    ph_state_t       state_q, state_d;
    logic [DT_W-1:0] cnt_q;
    logic [DT_W:0]   cnt_inc;
    logic            gap_done;

    assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
    assign gap_done = cnt_inc >= {1'b0, dead_cyc};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (req_lo)                state_d = PH_LOW;
                else if (req_hi && boot_ok) state_d = PH_HIGH;
            end
            PH_GAP: begin
                if (gap_done) begin
                    if (req_lo)                 state_d = PH_LOW;
                    else if (req_hi && boot_ok) state_d = PH_HIGH;
                    else                        state_d = PH_IDLE;
                end
            end
            PH_HIGH: if (!req_hi) state_d = PH_GAP;
            PH_LOW:  if (!req_lo) state_d = PH_GAP;
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != PH_GAP) cnt_q <= '0;
            else                   cnt_q <= cnt_inc[DT_W-1:0];
        end
    end

    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (state_q)
            PH_HIGH: gate_hi = 1'b1;
            PH_LOW:  gate_lo = 1'b1;
            default: ;
        endcase
    end

    // R9: a high gate rises only after the bootstrap flag was seen set
    p_boot_before_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(boot_ok));

    // R8: no direct hand-over between the two gates of a phase
    p_gap_after_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_hi) |-> !gate_lo);

    p_gap_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_lo) |-> !gate_hi);

endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
    import bgs_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      hall,
    input  logic            dir,
    input  logic            decay_slow,
    input  logic            sync_rect,
    input  logic            pwm,
    input  logic            brake_n,
    input  logic            drv_disable,
    input  logic            prot_coast,
    input  logic            prot_hs_inhibit,
    input  logic [2:0]      boot_ok,
    input  logic [DT_W-1:0] dead_cyc,
    output logic [2:0]      gate_hi,
    output logic [2:0]      gate_lo
);
    logic [NPH-1:0] hi_sel, lo_sel, req_hi, req_lo;
    logic           code_ok;

    bgs_commutator u_comm (
        .hall    (hall),
        .dir     (dir),
        .hi_sel  (hi_sel),
        .lo_sel  (lo_sel),
        .code_ok (code_ok)
    );

    bgs_drive_select u_sel (
        .hi_sel          (hi_sel),
        .lo_sel          (lo_sel),
        .code_ok         (code_ok),
        .pwm             (pwm),
        .decay_slow      (decay_slow),
        .sync_rect       (sync_rect),
        .brake_n         (brake_n),
        .drv_disable     (drv_disable),
        .prot_coast      (prot_coast),
        .prot_hs_inhibit (prot_hs_inhibit),
        .req_hi          (req_hi),
        .req_lo          (req_lo)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        bgs_phase_timer #(.DT_W(DT_W)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_hi   (req_hi[p]),
            .req_lo   (req_lo[p]),
            .boot_ok  (boot_ok[p]),
            .dead_cyc (dead_cyc),
            .gate_hi  (gate_hi[p]),
            .gate_lo  (gate_lo[p])
        );
    end

    // R7: disable empties the bridge one clock later
    p_disable_coast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_disable |=> (gate_hi == 3'b000) && (gate_lo == 3'b000));

    // R11: protection coast empties the bridge one clock later
    p_prot_coast_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prot_coast |=> (gate_hi == 3'b000) && (gate_lo == 3'b000));

    // R10: inhibit removes every high side one clock later
    p_hs_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prot_hs_inhibit |=> gate_hi == 3'b000);

    // R6: an active brake never leaves a high side on
    p_brake_no_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!brake_n && !drv_disable && !prot_coast) |=> gate_hi == 3'b000);

endmodule

// File: tb/bridge_gate_seq_tb_top.sv
`timescale 1ns/1ps
module bridge_gate_seq_tb_top;
    localparam int DT_W = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      hall = 3'b101;
    logic            dir = 1'b1;
    logic            decay_slow = 1'b0;
    logic            sync_rect = 1'b0;
    logic            pwm = 1'b1;
    logic            brake_n = 1'b1;
    logic            drv_disable = 1'b1;
    logic            prot_coast = 1'b0;
    logic            prot_hs_inhibit = 1'b0;
    logic [2:0]      boot_ok = 3'b111;
    logic [DT_W-1:0] dead_cyc = 10'd3;
    logic [2:0]      gate_hi, gate_lo;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bridge_gate_seq #(.DT_W(DT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .hall(hall), .dir(dir),
        .decay_slow(decay_slow), .sync_rect(sync_rect), .pwm(pwm),
        .brake_n(brake_n), .drv_disable(drv_disable), .prot_coast(prot_coast),
        .prot_hs_inhibit(prot_hs_inhibit), .boot_ok(boot_ok),
        .dead_cyc(dead_cyc), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got hi/lo %b/%b expected %b/%b", req,
                     got[5:3], got[2:0], exp[5:3], exp[2:0]);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // expected (high phase, low phase) pair from the requirement tables
    function automatic logic [5:0] pair(input logic [2:0] h, input logic d);
        logic [2:0] hi, lo;
        hi = 3'b000; lo = 3'b000;
        case (h)
            3'b101: begin hi = 3'b001; lo = 3'b010; end
            3'b100: begin hi = 3'b001; lo = 3'b100; end
            3'b110: begin hi = 3'b010; lo = 3'b100; end
            3'b010: begin hi = 3'b010; lo = 3'b001; end
            3'b011: begin hi = 3'b100; lo = 3'b001; end
            3'b001: begin hi = 3'b100; lo = 3'b010; end
            default: ;
        endcase
        return d ? {hi, lo} : {lo, hi};
    endfunction

    task automatic settle();
        repeat (int'(dead_cyc) + 5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_mode(input logic [2:0] h, input logic d, input logic p,
                            input logic s, input logic r);
        @(negedge clk);
        hall = h; dir = d; pwm = p; decay_slow = s; sync_rect = r;
        settle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; drv_disable = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 in reset", {gate_hi, gate_lo}, 6'b0);
        drv_disable = 1'b1;
        rst_n = 1'b1;
        settle();
        check("R12 after release", {gate_hi, gate_lo}, 6'b0);
        drv_disable = 1'b0;
    endtask

    task automatic t_commutation();
        logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        for (int d = 1; d >= 0; d--) begin
            for (int i = 0; i < 6; i++) begin
                run_mode(codes[i], d[0], 1'b1, 1'b0, 1'b0);
                check(d ? "R1 R3 forward step" : "R2 R3 reverse step",
                      {gate_hi, gate_lo}, pair(codes[i], d[0]));
            end
        end
    endtask

    task automatic t_illegal();
        run_mode(3'b000, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 code 000", {gate_hi, gate_lo}, 6'b0);
        run_mode(3'b111, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R4 code 111", {gate_hi, gate_lo}, 6'b0);
    endtask

    task automatic t_decay();
        logic [5:0] pr;
        pr = pair(3'b110, 1'b1);
        run_mode(3'b110, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 fast diode", {gate_hi, gate_lo}, 6'b0);
        run_mode(3'b110, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 slow diode", {gate_hi, gate_lo}, {3'b000, pr[2:0]});
        run_mode(3'b110, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R5 fast sync", {gate_hi, gate_lo}, {pr[2:0], pr[5:3]});
        run_mode(3'b110, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R5 slow sync", {gate_hi, gate_lo}, {3'b000, pr[2:0] | pr[5:3]});
    endtask

    task automatic t_brake();
        run_mode(3'b011, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk); brake_n = 1'b0;
        settle();
        check("R6 brake", {gate_hi, gate_lo}, {3'b000, 3'b111});
        @(negedge clk); hall = 3'b000;
        settle();
        check("R6 brake on illegal code", {gate_hi, gate_lo}, {3'b000, 3'b111});
        @(negedge clk); drv_disable = 1'b1;
        @(negedge clk);
        check("R7 disable over brake", {gate_hi, gate_lo}, 6'b0);
        @(negedge clk); drv_disable = 1'b0; prot_coast = 1'b1;
        settle();
        check("R11 coast over brake", {gate_hi, gate_lo}, 6'b0);
        @(negedge clk); prot_coast = 1'b0; brake_n = 1'b1;
    endtask

    task automatic t_inhibit();
        run_mode(3'b101, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk); prot_hs_inhibit = 1'b1;
        @(negedge clk);
        check("R10 inhibit", {gate_hi, gate_lo}, {3'b000, 3'b010});
        @(negedge clk); prot_hs_inhibit = 1'b0; prot_coast = 1'b1;
        @(negedge clk);
        check("R11 coast", {gate_hi, gate_lo}, 6'b0);
        @(negedge clk); prot_coast = 1'b0;
    endtask

    // PWM falls under fast synchronous decay: A hands high->low, B low->high
    task automatic t_deadtime(input int d);
        int off_a, off_b;
        bit a_done, b_done;
        @(negedge clk); dead_cyc = DT_W'(d);
        run_mode(3'b101, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R8 start state", {gate_hi, gate_lo}, {3'b001, 3'b010});
        @(negedge clk); pwm = 1'b0;
        off_a = 0; off_b = 0; a_done = 0; b_done = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); @(negedge clk);
            if (!a_done) begin
                if (gate_lo[0]) a_done = 1; else if (!gate_hi[0]) off_a++;
            end
            if (!b_done) begin
                if (gate_hi[1]) b_done = 1; else if (!gate_lo[1]) off_b++;
            end
        end
        check_int("R8 phase A gap", off_a, (d == 0) ? 1 : d);
        check_int("R8 phase B gap", off_b, (d == 0) ? 1 : d);
    endtask

    task automatic t_boot();
        @(negedge clk); drv_disable = 1'b1; dead_cyc = 10'd2;
        settle();
        hall = 3'b101; dir = 1'b1; pwm = 1'b1; decay_slow = 1'b0; sync_rect = 1'b0;
        boot_ok = 3'b110; drv_disable = 1'b0;
        settle();
        check("R9 high held for bootstrap", {gate_hi, gate_lo}, {3'b000, 3'b010});
        boot_ok = 3'b111;
        @(negedge clk);
        check("R9 high after bootstrap", {gate_hi, gate_lo}, {3'b001, 3'b010});
    endtask

    initial begin
        t_reset();
        t_commutation();
        t_illegal();
        t_decay();
        t_brake();
        t_inhibit();
        t_deadtime(4);
        t_deadtime(0);
        t_boot();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule